// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block builds the word a parallel NOR flash puts on its data bus while an embedded program or erase algorithm is running. The operation sequencer supplies the current operation state. The read path supplies the array word, a combined output/chip-enable read strobe (active low), a flag saying whether the read address falls in a sector under erase or erase-suspend, and the most significant bit of the byte being programmed. From these the block chooses, for each status bit, the rule that applies. It drives the data bus and the ready/busy pin.

Two toggle flip-flops give the polling bits their alternating behaviour. One is a general busy toggle and the other is a sector-qualified toggle. Each advances on a falling edge of the read strobe, and only in the states and sectors where its rule allows. Polling software tells the state apart by reading twice and comparing. Both outputs are registered, so a value appears one clock after the inputs that select it.

Top module: `fsr_status_reporter`

## Requirements
- R1: While `rst` is high at a clock edge, `dq` becomes all zeros and `ry_by` becomes 1. Both toggle flip-flops clear to 0 and the strobe history is taken as high.
- R2: The op_state encoding is 0 idle, 1 auto program, 2 auto erase, 3 erase suspended, 4 program during erase suspend, 5 timeout. Codes 6 and 7 act as idle. In idle, `dq` equals `array_data` and `ry_by` is 1.
- R3: In auto program, bit 7 is the inverse of `prog_dq7`, bit 6 is the busy toggle, bit 2 is 1, bits 5 and 3 are 0, and `ry_by` is 0.
- R4: In auto erase, bit 7 is 0, bit 6 is the busy toggle, bit 3 is 1, bit 2 is the sector toggle, bit 5 is 0, and `ry_by` is 0.
- R5: In erase suspended with `rd_in_sector` = 1, bit 7 is 1, bit 6 is the held busy toggle, bit 2 is the sector toggle, bits 5 and 3 are 0, and `ry_by` is 1.
- R6: In erase suspended with `rd_in_sector` = 0, `dq` equals `array_data` and `ry_by` is 1.
- R7: In program during erase suspend, bit 7 is the inverse of `prog_dq7`, bit 6 is the busy toggle, bit 2 is the sector toggle, bits 5 and 3 are 0, and `ry_by` is 0.
- R8: In timeout, bit 5 is 1, bit 7 is the inverse of `prog_dq7`, bit 6 is the busy toggle, bit 3 is 1, bit 2 is the sector toggle, and `ry_by` is 0.
- R9: The busy toggle inverts only on a read-strobe falling edge (strobe high at the previous edge, low at this one) in states 1, 2, 4 and 5. It holds otherwise, including while the strobe stays low.
- R10: The sector toggle inverts only on a read-strobe falling edge with `rd_in_sector` = 1 in states 2, 3, 4 and 5. It holds otherwise.
- R11: Whenever a status word is output (R3, R4, R5, R7, R8), bits 4, 1, 0 and every bit above 7 are 0.
- R12: `dq` and `ry_by` are registered. They show the value chosen by the inputs and toggle state at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_state | input | 3 | Embedded-operation state code |
| rd_strobe_n | input | 1 | Combined output/chip enable read strobe, active low |
| rd_in_sector | input | 1 | Read address is in an erasing, suspended or failed sector |
| prog_dq7 | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | DATA_W | Word read from the array |
| dq | output | DATA_W | Registered data bus value |
| ry_by | output | 1 | Registered ready (1) / busy (0) |

## Verification
Constrained-random cycles mix every state code, including the unused ones, with random strobe levels, sector flags, programmed bits and array words. A reference model predicts each bus word, so toggle advances are distinguished from holds and in-sector reads from out-of-sector reads. Directed sequences perform repeated strobe falls in erase and in suspend. These show that the busy toggle alternates in erase but freezes in suspend while the sector toggle keeps moving. A strobe held low across several cycles shows that a level, unlike an edge, advances nothing.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_SUSP  = 3'd3,
    OP_PSUSP = 3'd4,
    OP_TMO   = 3'd5
  } op_e;

  localparam int STAT_W = 8;

  function automatic logic busy_toggles(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_PSUSP) || (op == OP_TMO);
  endfunction

  function automatic logic sector_toggles(input logic [2:0] op);
    return (op == OP_ERASE) || (op == OP_SUSP) || (op == OP_PSUSP) || (op == OP_TMO);
  endfunction
endpackage

// File: rtl/fsr_strobe_edge.sv
module fsr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic fall
);
  logic prev_n;

  always_ff @(posedge clk) begin
    if (rst) prev_n <= 1'b1;
    else     prev_n <= strobe_n;
  end

  assign fall = prev_n & ~strobe_n;
endmodule

// File: rtl/fsr_toggle_pair.sv
module fsr_toggle_pair
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fall,
  input  logic [2:0] op,
  input  logic       in_sector,
  output logic       tgl_busy,
  output logic       tgl_sector
);
  logic adv_busy, adv_sector;

  assign adv_busy   = fall & busy_toggles(op);
  assign adv_sector = fall & in_sector & sector_toggles(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_busy   <= 1'b0;
      tgl_sector <= 1'b0;
    end else begin
      if (adv_busy)   tgl_busy   <= ~tgl_busy;
      if (adv_sector) tgl_sector <= ~tgl_sector;
    end
  end
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic              in_sector,
  input  logic              prog_dq7,
  input  logic [DATA_W-1:0] array_data,
  input  logic              tgl_busy,
  input  logic              tgl_sector,
  output logic [DATA_W-1:0] word,
  output logic              ready
);
  logic [STAT_W-1:0] stat;
  logic              use_stat;

  always_comb begin
    stat     = '0;
    use_stat = 1'b1;
    ready    = 1'b0;
    case (op)
      OP_PROG: begin
        stat[7] = ~prog_dq7;
        stat[6] = tgl_busy;
        stat[2] = 1'b1;
      end
      OP_ERASE: begin
        stat[6] = tgl_busy;
        stat[3] = 1'b1;
        stat[2] = tgl_sector;
      end
      OP_SUSP: begin
        ready = 1'b1;
        if (in_sector) begin
          stat[7] = 1'b1;
          stat[6] = tgl_busy;
          stat[2] = tgl_sector;
        end else begin
          use_stat = 1'b0;
        end
      end
      OP_PSUSP: begin
        stat[7] = ~prog_dq7;
        stat[6] = tgl_busy;
        stat[2] = tgl_sector;
      end
      OP_TMO: begin
        stat[7] = ~prog_dq7;
        stat[6] = tgl_busy;
        stat[5] = 1'b1;
        stat[3] = 1'b1;
        stat[2] = tgl_sector;
      end
      default: begin
        use_stat = 1'b0;
        ready    = 1'b1;
      end
    endcase
  end

  generate
    if (DATA_W > STAT_W) begin : g_wide
      assign word = use_stat ? {{(DATA_W-STAT_W){1'b0}}, stat} : array_data;
    end else begin : g_byte
      assign word = use_stat ? stat : array_data;
    end
  endgenerate
endmodule

// File: rtl/fsr_status_reporter.sv
module fsr_status_reporter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_state,
  input  logic              rd_strobe_n,
  input  logic              rd_in_sector,
  input  logic              prog_dq7,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq,
  output logic              ry_by
);
  logic              fall;
  logic              tgl_busy, tgl_sector;
  logic [DATA_W-1:0] word_d;
  logic              ready_d;

  fsr_strobe_edge u_edge (
    .clk(clk), .rst(rst), .strobe_n(rd_strobe_n), .fall(fall)
  );

  fsr_toggle_pair u_tgl (
    .clk(clk), .rst(rst), .fall(fall), .op(op_state), .in_sector(rd_in_sector),
    .tgl_busy(tgl_busy), .tgl_sector(tgl_sector)
  );

  fsr_status_mux #(.DATA_W(DATA_W)) u_mux (
    .op(op_state), .in_sector(rd_in_sector), .prog_dq7(prog_dq7),
    .array_data(array_data), .tgl_busy(tgl_busy), .tgl_sector(tgl_sector),
    .word(word_d), .ready(ready_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq    <= '0;
      ry_by <= 1'b1;
    end else begin
      dq    <= word_d;
      ry_by <= ready_d;
    end
  end
endmodule

// File: rtl/fsr_status_reporter_chk.sv
module fsr_status_reporter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_state,
  input logic              rd_strobe_n,
  input logic              rd_in_sector,
  input logic              prog_dq7,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] dq,
  input logic              ry_by,
  input logic              tgl_busy,
  input logic              tgl_sector
);
  AST_RESET_READY: assert property (@(posedge clk) rst |=> ry_by && dq == '0); // R1
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_state == 3'd0) |=> (dq == $past(array_data)) && ry_by); // R2
  AST_PROG_DQ7: assert property (@(posedge clk) disable iff (rst)
    (op_state == 3'd1) |=> (dq[7] == !$past(prog_dq7)) && !ry_by); // R3
  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (op_state == 3'd2) |=> !ry_by && dq[3] && !dq[7]); // R4
  AST_SUSP_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (op_state == 3'd3 && rd_in_sector) |=> ry_by && dq[7]); // R5
  AST_TMO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (op_state == 3'd5) |=> dq[5] && !ry_by); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_n |=> $stable(tgl_busy)); // R9
  AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_in_sector |=> $stable(tgl_sector)); // R10
endmodule

bind fsr_status_reporter fsr_status_reporter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_state(op_state), .rd_strobe_n(rd_strobe_n),
  .rd_in_sector(rd_in_sector), .prog_dq7(prog_dq7), .array_data(array_data),
  .dq(dq), .ry_by(ry_by), .tgl_busy(tgl_busy), .tgl_sector(tgl_sector)
);

// File: tb/fsr_status_reporter_test.sv
`timescale 1ns/1ps
module fsr_status_reporter_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_state = 3'd0;
  logic          rd_strobe_n = 1'b1;
  logic          rd_in_sector = 1'b0;
  logic          prog_dq7 = 1'b0;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] dq;
  logic          ry_by;

  int tests = 0;
  int fails = 0;

  // model state
  logic          m_busy = 1'b0, m_sec = 1'b0, m_prev = 1'b1;
  logic [DW-1:0] e_dq = '0;
  logic          e_rdy = 1'b1;
  string         e_tag = "R1";

  always #2 clk = ~clk;

  fsr_status_reporter #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .op_state(op_state), .rd_strobe_n(rd_strobe_n),
    .rd_in_sector(rd_in_sector), .prog_dq7(prog_dq7), .array_data(array_data),
    .dq(dq), .ry_by(ry_by)
  );

  function automatic logic [DW:0] expect_word(input logic [2:0] op, input logic sec,
      input logic p7, input logic [DW-1:0] arr, input logic tb, input logic ts);
    logic [DW-1:0] w;
    w = '0;
    case (op)
      3'd1: begin w[7] = ~p7; w[6] = tb; w[2] = 1'b1; return {1'b0, w}; end
      3'd2: begin w[6] = tb; w[3] = 1'b1; w[2] = ts; return {1'b0, w}; end
      3'd3: begin
        if (!sec) return {1'b1, arr};
        w[7] = 1'b1; w[6] = tb; w[2] = ts; return {1'b1, w};
      end
      3'd4: begin w[7] = ~p7; w[6] = tb; w[2] = ts; return {1'b0, w}; end
      3'd5: begin w[7] = ~p7; w[6] = tb; w[5] = 1'b1; w[3] = 1'b1; w[2] = ts; return {1'b0, w}; end
      default: return {1'b1, arr};
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic sec);
    case (op)
      3'd1: return "R3/R11/R12";
      3'd2: return "R4/R9/R10/R11";
      3'd3: return sec ? "R5/R10/R11" : "R6";
      3'd4: return "R7/R9/R10/R11";
      3'd5: return "R8/R9/R10/R11";
      default: return "R2/R12";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [DW:0] r;
    logic f;
    if (rst) begin
      e_dq = '0; e_rdy = 1'b1; e_tag = "R1";
      m_busy = 1'b0; m_sec = 1'b0; m_prev = 1'b1;
    end else begin
      r = expect_word(op_state, rd_in_sector, prog_dq7, array_data, m_busy, m_sec);
      e_dq = r[DW-1:0]; e_rdy = r[DW];
      e_tag = tag_of(op_state, rd_in_sector);
      f = m_prev & ~rd_strobe_n;
      if (f && (op_state == 3'd1 || op_state == 3'd2 || op_state == 3'd4 || op_state == 3'd5))
        m_busy = ~m_busy;
      if (f && rd_in_sector && (op_state >= 3'd2 && op_state <= 3'd5))
        m_sec = ~m_sec;
      m_prev = rd_strobe_n;
    end
  end

  task automatic check_now();
    tests++;
    if (dq !== e_dq || ry_by !== e_rdy) begin
      fails++;
      $display("FAIL %s: dq=%h ry_by=%b expected dq=%h ry_by=%b", e_tag, dq, ry_by, e_dq, e_rdy);
    end
  endtask

  // apply inputs at negedge after checking the previous result
  task automatic step(input logic [2:0] op, input logic sn, input logic sec,
                      input logic p7, input logic [DW-1:0] arr);
    @(negedge clk);
    check_now();
    op_state = op; rd_strobe_n = sn; rd_in_sector = sec; prog_dq7 = p7; array_data = arr;
  endtask

  task automatic expect_bit(input string tag, input int bitn, input logic val);
    tests++;
    if (dq[bitn] !== val) begin
      fails++;
      $display("FAIL %s: dq[%0d]=%b expected %b", tag, bitn, dq[bitn], val);
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic b0, b1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_now();                          // R1 reset state
    rst = 1'b0;

    // R9: erase, two reads -> busy toggle differs
    step(3'd2, 1'b1, 1'b1, 1'b0, 16'h1234);
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    step(3'd2, 1'b1, 1'b1, 1'b0, 16'h1234);
    @(negedge clk); b0 = dq[6];
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    @(negedge clk); b1 = dq[6];
    tests++;
    if (b0 === b1) begin fails++; $display("FAIL R9: dq6 %b then %b, expected change", b0, b1); end
    // R9: strobe held low -> no further change
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h1234);
    @(negedge clk); expect_bit("R9 held strobe", 6, b1);

    // R5/R10: suspend in sector, busy frozen while sector toggle moves
    step(3'd3, 1'b1, 1'b1, 1'b0, 16'hBEEF);
    step(3'd3, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    step(3'd3, 1'b1, 1'b1, 1'b0, 16'hBEEF);
    step(3'd3, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    step(3'd3, 1'b0, 1'b1, 1'b0, 16'hBEEF);
    @(negedge clk); expect_bit("R5 frozen busy toggle", 6, b1);
    // R6: out of sector returns array data
    step(3'd3, 1'b1, 1'b0, 1'b0, 16'hA5C3);
    step(3'd3, 1'b0, 1'b0, 1'b0, 16'hA5C3);

    // R8 timeout, R3 program, R2 unused code
    step(3'd5, 1'b1, 1'b1, 1'b1, 16'h0);
    step(3'd5, 1'b0, 1'b1, 1'b1, 16'h0);
    step(3'd1, 1'b1, 1'b0, 1'b0, 16'h0);
    step(3'd7, 1'b1, 1'b0, 1'b0, 16'hFFFF);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(0, 5)) : 3'($urandom_range(6, 7));
      step(op, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), DW'($urandom));
    end

    // reset mid-operation (R1)
    step(3'd2, 1'b0, 1'b1, 1'b0, 16'h5555);
    @(negedge clk); check_now();
    rst = 1'b1;
    @(negedge clk); e_tag = "R1"; check_now();
    rst = 1'b0;
    step(3'd0, 1'b1, 1'b0, 1'b0, 16'h00FF);
    step(3'd0, 1'b1, 1'b0, 1'b0, 16'h00FF);
    @(negedge clk); check_now();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule